// File: doc/BRIEF.md
# Paged EEPROM Write Engine

This block is a clock-synchronous model of a byte-alterable nonvolatile memory core. Its storage is a register array. It watches three active-low strobes (chip select, write strobe, output enable), an address bus and a data input bus. Every strobe is sampled on the rising clock edge.

A write cycle deposits one byte into a page buffer. The upper address bits of the first byte fix the page, and later bytes may land at any offset inside that page. While bytes keep arriving inside a load window, the page stays open. When the window expires, a self-timed programming phase copies every loaded byte into the array in one step.

During programming, any read returns a status word instead of array data. Bit 7 of that word is the inverse of bit 7 of the last byte loaded. Bit 6 changes after every completed read. Software can therefore detect the end of programming either by comparing the data or by watching for the toggling to stop. Reads at other times return array contents. An enable output tells the pad logic when to drive the bus. All delays are parameters counted in clock cycles.

Top module: `eep_page_engine`

## Requirements
- R1: After reset the block is idle with `busy` low, and every array byte reads as 8'hFF.
- R2: `dout_en` is high exactly when `ce_n` and `oe_n` are both low. Outside programming, `dout` then equals the array byte at `addr`.
- R3: A byte load starts in the cycle where `ce_n` and `we_n` are both low and `oe_n` is high, having not all been so in the previous sample. The address is taken in that start cycle. The data stored is the `din` value of the last sample before `ce_n` or `we_n` returns high. If `oe_n` goes low first, or is low throughout, nothing is stored.
- R4: The first load of a page locks the page number `addr[ADDR_W-1:7]`, and `addr[6:0]` picks one of 128 byte slots. A load whose page number differs is discarded and does not restart the window. A slot loaded twice keeps the later byte.
- R5: Programming starts at the LOAD_WIN-th clock edge after the start cycle of the last accepted load, provided no load is then in progress.
- R6: Programming lasts PROG_CYC cycles, with `busy` high throughout. At its end, every loaded slot is written to the array, and bytes of the page that were not loaded keep their old values. Write cycles during programming are ignored.
- R7: A read during programming, at any address, returns a status word. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 is 0 at the start of programming and inverts after each read ends. Bits 5:0 are 0.
- R8: If the window expires with no byte stored (all loads aborted), the block returns to idle without programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or programming status |
| dout_en | output | 1 | Bus drive enable; bus is high impedance when low |
| busy | output | 1 | High while the programming phase runs |

## Verification
Writes are tried in two forms: one with the write strobe falling last and one with chip select falling last. In both, the address and data buses change mid-cycle, which separates start-cycle address capture from last-sample data capture. A multi-byte page is tried with a repeated slot, a foreign-page load and gaps just inside the window, which tells apart slot overwrite, page locking and window restart. Polling reads during programming follow bytes with bit 7 set and clear, checking inversion and toggling. Aborted, output-enable-blocked and during-programming writes must leave the array untouched.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_e;

    // strobe events derived each cycle
    typedef struct packed {
        logic start;    // write select just became true
        logic finish;   // ce_n or we_n is high now
        logic abort;    // oe_n is low now
        logic rd_done;  // a read access just ended
    } strobe_ev_t;

    // status word returned while programming
    function automatic logic [DATA_W-1:0] status_word(input logic last_msb,
                                                      input logic tgl);
        return {~last_msb, tgl, {(DATA_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/eep_strobe_decode.sv
module eep_strobe_decode
    import eep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    output strobe_ev_t ev
);
    logic wsel, rsel, wsel_q, rsel_q;

    assign wsel = !ce_n && !we_n && oe_n;
    assign rsel = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wsel_q <= 1'b0;
            rsel_q <= 1'b0;
        end else begin
            wsel_q <= wsel;
            rsel_q <= rsel;
        end
    end

    always_comb begin
        ev.start   = wsel && !wsel_q;
        ev.finish  = ce_n || we_n;
        ev.abort   = !oe_n;
        ev.rd_done = rsel_q && !rsel;
    end
endmodule

// File: rtl/eep_page_buffer.sv
module eep_page_buffer
    import eep_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [PAGE_W-1:0]                wr_off,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             clr,
    output logic [(1<<PAGE_W)*DATA_W-1:0]    bytes_o,
    output logic [(1<<PAGE_W)-1:0]           valid_o,
    output logic                             any_o
);
    localparam int NBYTE = 1 << PAGE_W;

    for (genvar g = 0; g < NBYTE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                valid_o[g] <= 1'b0;
                bytes_o[g*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && wr_off == PAGE_W'(g)) begin
                valid_o[g] <= 1'b1;
                bytes_o[g*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    assign any_o = |valid_o;
endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 7
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                commit,
    input  logic [ADDR_W-PAGE_W-1:0]            page,
    input  logic [(1<<PAGE_W)*DATA_W-1:0]       bytes_i,
    input  logic [(1<<PAGE_W)-1:0]              valid_i,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NBYTE = 1 << PAGE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < NBYTE; i++) begin
                if (valid_i[i]) mem[{page, PAGE_W'(i)}] <= bytes_i[i*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_page_engine.sv
module eep_page_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAGE_W   = 7,
    parameter int LOAD_WIN = 5000,
    parameter int PROG_CYC = 150000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int NBYTE = 1 << PAGE_W;
    localparam int MAXC  = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int TMR_W = $clog2(MAXC + 1);

    strobe_ev_t           ev;
    eep_state_e           state_q;
    logic [TMR_W-1:0]     tmr_q;
    logic                 act_q;
    logic [PAGE_W-1:0]    off_q;
    logic [DATA_W-1:0]    data_q;
    logic                 last_msb_q;
    logic                 tgl_q;
    logic [PG_W-1:0]      page_q;

    logic [NBYTE*DATA_W-1:0] pg_bytes;
    logic [NBYTE-1:0]        pg_valid;
    logic                    pg_any;
    logic [DATA_W-1:0]       arr_data;

    logic            accept, load_done, load_abort, win_over, prog_last;
    logic [PG_W-1:0] addr_page;

    eep_strobe_decode u_dec (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ev(ev)
    );

    assign addr_page  = addr[ADDR_W-1:PAGE_W];
    assign accept     = ev.start && (state_q == ST_IDLE ||
                        (state_q == ST_LOAD && addr_page == page_q));
    assign load_done  = act_q && ev.finish;
    assign load_abort = act_q && !ev.finish && ev.abort;
    assign win_over   = state_q == ST_LOAD && !act_q && !accept &&
                        tmr_q == TMR_W'(LOAD_WIN - 1);
    assign prog_last  = state_q == ST_PROG && tmr_q == TMR_W'(PROG_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            tmr_q      <= '0;
            act_q      <= 1'b0;
            off_q      <= '0;
            data_q     <= '0;
            last_msb_q <= 1'b0;
            tgl_q      <= 1'b0;
            page_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_LOAD;
                    page_q  <= addr_page;
                    tmr_q   <= '0;
                end
                ST_LOAD: begin
                    if (accept) begin
                        tmr_q <= '0;
                    end else if (win_over) begin
                        state_q <= pg_any ? ST_PROG : ST_IDLE;
                        tmr_q   <= '0;
                        tgl_q   <= 1'b0;
                    end else if (tmr_q < TMR_W'(LOAD_WIN - 1)) begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prog_last) begin
                        state_q <= ST_IDLE;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                    if (ev.rd_done) tgl_q <= ~tgl_q;
                end
                default: state_q <= ST_IDLE;
            endcase

            if (accept) act_q <= 1'b1;
            else if (load_done || load_abort) act_q <= 1'b0;

            if (accept) off_q <= addr[PAGE_W-1:0];
            if (accept || (act_q && !ev.finish && !ev.abort)) data_q <= din;
            if (load_done) last_msb_q <= data_q[DATA_W-1];
        end
    end

    eep_page_buffer #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst(rst), .wr_en(load_done), .wr_off(off_q),
        .wr_data(data_q), .clr(prog_last),
        .bytes_o(pg_bytes), .valid_o(pg_valid), .any_o(pg_any)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
        .clk(clk), .rst(rst), .commit(prog_last), .page(page_q),
        .bytes_i(pg_bytes), .valid_i(pg_valid),
        .rd_addr(addr), .rd_data(arr_data)
    );

    assign busy    = state_q == ST_PROG;
    assign dout_en = !ce_n && !oe_n;
    assign dout    = busy ? status_word(last_msb_q, tgl_q) : arr_data;

    // R6: no byte is stored while programming
    a_r6_no_load_in_prog: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load_done);
    // R6: programming phase never outlasts its length
    a_r6_prog_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tmr_q < TMR_W'(PROG_CYC)));
    // R4: page number frozen while collecting
    a_r4_page_locked: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && $past(state_q) == ST_LOAD) |-> $stable(page_q));
    // R7: each finished read during programming inverts the toggle bit
    a_r7_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (busy && ev.rd_done) |=> (tgl_q != $past(tgl_q)));
    // R8: programming only starts with at least one stored byte
    a_r8_nonempty_prog: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> pg_any);
endmodule

// File: tb/tb_eep_page_engine.sv
module tb_eep_page_engine;
    localparam int CLK_P    = 10;
    localparam int ADDR_W   = 11;
    localparam int LOAD_WIN = 20;
    localparam int PROG_CYC = 40;
    localparam int DEPTH    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_en, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    eep_page_engine #(.ADDR_W(ADDR_W), .PAGE_W(7), .LOAD_WIN(LOAD_WIN),
                      .PROG_CYC(PROG_CYC)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_pb [128];
    bit         m_pv [128];
    int         m_st;          // 0 idle, 1 collecting, 2 programming
    int         m_tmr, m_off, m_page;
    bit         m_act, m_tg, m_wq, m_rq;
    logic [7:0] m_dq, m_last;

    task automatic model_reset();
        foreach (m_mem[i]) m_mem[i] = 8'hFF;
        foreach (m_pv[i]) m_pv[i] = 0;
        m_st = 0; m_tmr = 0; m_off = 0; m_page = 0;
        m_act = 0; m_tg = 0; m_wq = 0; m_rq = 0; m_dq = 0; m_last = 0;
    endtask

    task automatic model_step();
        bit w, r, start, old_act, acc, any;
        w = !ce_n && !we_n && oe_n;
        r = !ce_n && !oe_n;
        start = w && !m_wq;
        old_act = m_act;
        acc = 0;
        if (m_st == 2) begin
            if (m_rq && !r) m_tg = !m_tg;
            if (m_tmr == PROG_CYC - 1) begin
                for (int i = 0; i < 128; i++) begin
                    if (m_pv[i]) m_mem[m_page*128 + i] = m_pb[i];
                    m_pv[i] = 0;
                end
                m_st = 0; m_tmr = 0;
            end else m_tmr++;
        end else begin
            if (m_act) begin
                if (ce_n || we_n) begin
                    m_pb[m_off] = m_dq; m_pv[m_off] = 1; m_last = m_dq; m_act = 0;
                end else if (!oe_n) m_act = 0;
                else m_dq = din;
            end else if (start) begin
                if (m_st == 0 || int'(addr >> 7) == m_page) begin
                    acc = 1;
                    if (m_st == 0) begin m_page = int'(addr >> 7); m_st = 1; end
                    m_tmr = 0; m_act = 1; m_off = int'(addr & 127); m_dq = din;
                end
            end
            if (m_st == 1 && !acc) begin
                if (!old_act && m_tmr == LOAD_WIN - 1) begin
                    any = 0;
                    foreach (m_pv[i]) if (m_pv[i]) any = 1;
                    m_st = any ? 2 : 0; m_tmr = 0; m_tg = 0;
                end else if (m_tmr < LOAD_WIN - 1) m_tmr++;
            end
        end
        m_wq = w; m_rq = r;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) model_reset();
        else model_step();
    end

    // per-cycle comparison, sampled a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (!rst) begin
            checks++;
            if (dout_en !== (!ce_n && !oe_n)) begin
                errors++;
                $display("FAIL R2 dout_en actual %b expected %b", dout_en, !ce_n && !oe_n);
            end
            checks++;
            if (busy !== (m_st == 2)) begin
                errors++;
                $display("FAIL R5 or R6 busy actual %b expected %b", busy, m_st == 2);
            end
            if (!ce_n && !oe_n) begin
                logic [7:0] e;
                e = (m_st == 2) ? {~m_last[7], m_tg, 6'b0} : m_mem[addr];
                checks++;
                if (dout !== e) begin
                    errors++;
                    $display("FAIL %s dout at %h actual %h expected %h",
                             (m_st == 2) ? "R7" : "R2", addr, dout, e);
                end
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp,
                          input string tag);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        #(CLK_P/4);
        checks++;
        if (dout !== exp || dout_en !== 1'b1) begin
            errors++;
            $display("FAIL %s read %h actual %h expected %h", tag, a, dout, exp);
        end
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic chk_busy(input logic exp, input string tag);
        @(negedge clk); #(CLK_P/4);
        checks++;
        if (busy !== exp) begin
            errors++;
            $display("FAIL %s busy actual %b expected %b", tag, busy, exp);
        end
    endtask

    // write strobe falls last; bus changes mid-cycle
    task automatic wr_we(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 0; oe_n = 1; addr = a;
        @(negedge clk); we_n = 0; din = ~d;
        @(negedge clk); din = d; addr = ~a;
        @(negedge clk); we_n = 1; din = 8'h00;
        @(negedge clk); ce_n = 1;
    endtask

    // chip select falls last
    task automatic wr_ce(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk); we_n = 0; oe_n = 1; addr = a;
        @(negedge clk); ce_n = 0; din = d;
        @(negedge clk); ;
        @(negedge clk); ce_n = 1; din = 8'h00;
        @(negedge clk); we_n = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_busy(input logic lvl);
        for (int i = 0; i < 200 && busy !== lvl; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk_busy(1'b0, "R1");
        chk_rd(11'h000, 8'hFF, "R1");
        chk_rd(11'h7FF, 8'hFF, "R1");

        // R3 single byte, write-strobe controlled
        wr_we(11'h123, 8'h5A);
        wait_busy(1'b1);
        // R7 polling: bit7 inverted (0->1), toggle 0 then 1
        chk_rd(11'h000, 8'h80, "R7");
        chk_rd(11'h555, 8'hC0, "R7");
        chk_rd(11'h123, 8'h80, "R7");
        // R6 write during programming ignored
        wr_we(11'h123, 8'h00);
        wr_we(11'h010, 8'h33);
        wait_busy(1'b0);
        idle(LOAD_WIN + 5);
        chk_busy(1'b0, "R6");
        chk_rd(11'h123, 8'h5A, "R3");
        chk_rd(11'h010, 8'hFF, "R6");

        // R4 page of several bytes, chip-select controlled, gaps in window
        wr_ce(11'h280, 8'h11);
        idle(10);
        wr_ce(11'h281, 8'h22);
        wr_ce(11'h305, 8'h99);          // other page: discarded
        wr_ce(11'h2FF, 8'h33);
        idle(12);
        wr_ce(11'h281, 8'hC4);          // slot rewrite, last byte bit7 set
        chk_busy(1'b0, "R5");
        wait_busy(1'b1);
        chk_rd(11'h280, 8'h00, "R7");
        chk_rd(11'h280, 8'h40, "R7");
        chk_rd(11'h280, 8'h00, "R7");
        wait_busy(1'b0);
        chk_rd(11'h280, 8'h11, "R4");
        chk_rd(11'h281, 8'hC4, "R4");
        chk_rd(11'h2FF, 8'h33, "R4");
        chk_rd(11'h305, 8'hFF, "R4");
        chk_rd(11'h282, 8'hFF, "R6");

        // R5 window edge: start of a lone load then count cycles
        wr_we(11'h400, 8'h01);
        idle(LOAD_WIN - 8);
        chk_busy(1'b0, "R5");
        wait_busy(1'b1);
        wait_busy(1'b0);
        chk_rd(11'h400, 8'h01, "R5");

        // R3 / R8 load aborted by output enable
        @(negedge clk); ce_n = 0; oe_n = 1; addr = 11'h500; din = 8'h42;
        @(negedge clk); we_n = 0;
        @(negedge clk); oe_n = 0;
        @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
        idle(LOAD_WIN + 10);
        chk_busy(1'b0, "R8");
        chk_rd(11'h500, 8'hFF, "R3");

        // R3 output enable low all along inhibits the write
        @(negedge clk); oe_n = 0; ce_n = 0; addr = 11'h600; din = 8'h77;
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1; oe_n = 1;
        idle(LOAD_WIN + 10);
        chk_busy(1'b0, "R3");
        chk_rd(11'h600, 8'hFF, "R3");

        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule